// File: doc/BRIEF.md
# 5B/4B Symbol Pair Decoder with Line-State Tracking

This block sits behind a symbol aligner on a ring-network receive path. Each accepted cycle it takes one aligned pair of 5-bit code groups, a high (first-received) symbol and a low (second-received) symbol. Each group is turned into a 4-bit nibble and a 3-bit class tag. The class tag separates data from the control symbols. It also tells Quiet apart from a code violation, even though both decode to the same nibble.

A tracker watches the decoded pairs and keeps the receive line state. A starting-delimiter pair moves it to Active. It stays Active while frame symbols arrive. A qualifying run of idle pairs moves it to Idle. Anything else gives a generic non-active code. The nibbles, the tags and the line state leave the block from registers, one pair-clock after the pair is presented. Cycles without a valid pair change no state.

Top module: `fdx_pair_decoder`

## Requirements
- R1: The sixteen data code groups decode with class 0 (data) to these nibbles: 11110→0, 01001→1, 10100→2, 10101→3, 01010→4, 01011→5, 01110→6, 01111→7, 10010→8, 10011→9, 10110→A, 10111→B, 11010→C, 11011→D, 11100→E, 11101→F.
- R2: Control groups decode to a nibble and class as follows. 11111 Idle gives 1010/class 1. 00100 Halt gives 0001/class 2. J 11000 and K 10001 give 1101/class 3. 01101 T gives 0101/class 4. 00111 R gives 0110/class 5. 11001 S gives 0111/class 5. 00000 Quiet gives 0010/class 6.
- R3: Every other code group (00001, 00010, 00011, 00101, 00110, 01000, 01100, 10000) is a violation: nibble 0010, class 7.
- R4: A pair presented with in_valid high at a clock edge appears on the outputs, with out_valid high, after that edge. out_valid is low after an edge where in_valid was low.
- R5: A pair with J (11000) as the high symbol and K (10001) as the low symbol sets line_state to Active (01), from any state.
- R6: While Active, a pair whose two symbols are each data, T, R or S keeps line_state Active.
- R7: While Active, a pair holding a violation, Halt, Quiet, Idle or an unpaired J/K half sets line_state to non-active (00).
- R8: line_state becomes Idle (10) once two consecutive valid pairs are both Idle-Idle. It stays Idle while further idle pairs arrive. Any other pair that is not a JK pair gives non-active (00).
- R9: After synchronous reset, line_state is non-active (00) and out_valid is low.
- R10: Cycles with in_valid low leave line_state and the idle-pair count unchanged, so an idle run interrupted only by gaps still qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pair clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A code-group pair is present |
| sym_hi | input | 5 | First-received code group of the pair |
| sym_lo | input | 5 | Second-received code group of the pair |
| out_valid | output | 1 | Registered pair outputs are valid |
| nib_hi | output | 4 | Decoded nibble of the high symbol |
| nib_lo | output | 4 | Decoded nibble of the low symbol |
| cls_hi | output | 3 | Class tag of the high symbol |
| cls_lo | output | 3 | Class tag of the low symbol |
| line_state | output | 2 | 00 non-active, 01 Active, 10 Idle |

## Verification
The assertions assume that sym_hi and sym_lo are already aligned on symbol boundaries. They also assume that in_valid is a plain qualifier, so an invalid cycle carries no meaning of its own. The stimulus always presents whole pairs on a negative edge, so the symbol fields never change within a cycle. Gap cycles are inserted by dropping in_valid and never by sending partial pairs. Each of the 32 code groups is applied in both the high and the low position. The line-state sequences go through every entry and exit path of Active and Idle, including idle runs split by gaps.

// File: rtl/fdx_pkg.sv
package fdx_pkg;
    localparam int SYM_W = 5;
    localparam int NIB_W = 4;
    localparam int CLS_W = 3;
    localparam int LS_W  = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_DATA  = 3'd0,
        CLS_IDLE  = 3'd1,
        CLS_HALT  = 3'd2,
        CLS_JK    = 3'd3,
        CLS_T     = 3'd4,
        CLS_RS    = 3'd5,
        CLS_QUIET = 3'd6,
        CLS_VIOL  = 3'd7
    } sym_class_e;

    typedef enum logic [LS_W-1:0] {
        LS_NONE   = 2'd0,
        LS_ACTIVE = 2'd1,
        LS_IDLE   = 2'd2
    } line_state_e;

    typedef struct packed {
        logic [NIB_W-1:0] nib;
        sym_class_e       cls;
        logic             k_half;  // set only for the second half of the delimiter
    } sym_dec_t;

    localparam logic [SYM_W-1:0] CODE_IDLE = 5'b11111;
    localparam logic [SYM_W-1:0] CODE_J    = 5'b11000;
    localparam logic [SYM_W-1:0] CODE_K    = 5'b10001;

    // Symbols that may appear inside a frame without dropping Active
    function automatic logic in_frame(sym_class_e c);
        return (c == CLS_DATA) || (c == CLS_T) || (c == CLS_RS);
    endfunction
endpackage

// File: rtl/fdx_sym_decode.sv
module fdx_sym_decode
    import fdx_pkg::*;
(
    input  logic [SYM_W-1:0] code,
    output sym_dec_t         dec
);
    always_comb begin
        dec = '{nib: 4'h2, cls: CLS_VIOL, k_half: 1'b0};
        unique case (code)
            5'b11110: dec = '{4'h0, CLS_DATA, 1'b0};
            5'b01001: dec = '{4'h1, CLS_DATA, 1'b0};
            5'b10100: dec = '{4'h2, CLS_DATA, 1'b0};
            5'b10101: dec = '{4'h3, CLS_DATA, 1'b0};
            5'b01010: dec = '{4'h4, CLS_DATA, 1'b0};
            5'b01011: dec = '{4'h5, CLS_DATA, 1'b0};
            5'b01110: dec = '{4'h6, CLS_DATA, 1'b0};
            5'b01111: dec = '{4'h7, CLS_DATA, 1'b0};
            5'b10010: dec = '{4'h8, CLS_DATA, 1'b0};
            5'b10011: dec = '{4'h9, CLS_DATA, 1'b0};
            5'b10110: dec = '{4'hA, CLS_DATA, 1'b0};
            5'b10111: dec = '{4'hB, CLS_DATA, 1'b0};
            5'b11010: dec = '{4'hC, CLS_DATA, 1'b0};
            5'b11011: dec = '{4'hD, CLS_DATA, 1'b0};
            5'b11100: dec = '{4'hE, CLS_DATA, 1'b0};
            5'b11101: dec = '{4'hF, CLS_DATA, 1'b0};
            5'b11111: dec = '{4'hA, CLS_IDLE, 1'b0};
            5'b00100: dec = '{4'h1, CLS_HALT, 1'b0};
            5'b11000: dec = '{4'hD, CLS_JK, 1'b0};
            5'b10001: dec = '{4'hD, CLS_JK, 1'b1};
            5'b01101: dec = '{4'h5, CLS_T, 1'b0};
            5'b00111: dec = '{4'h6, CLS_RS, 1'b0};
            5'b11001: dec = '{4'h7, CLS_RS, 1'b0};
            5'b00000: dec = '{4'h2, CLS_QUIET, 1'b0};
            default:  dec = '{4'h2, CLS_VIOL, 1'b0};
        endcase
    end

    always_comb begin
        // R2
        quiet_nib_chk: assert (dec.cls != CLS_QUIET || dec.nib == 4'h2);
        // R3
        viol_nib_chk: assert (dec.cls != CLS_VIOL || dec.nib == 4'h2);
    end
endmodule

// File: rtl/fdx_line_tracker.sv
module fdx_line_tracker
    import fdx_pkg::*;
#(
    parameter int IDLE_PAIRS = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  sym_dec_t    dec_hi,
    input  sym_dec_t    dec_lo,
    output line_state_e state
);
    localparam int CNT_W = $clog2(IDLE_PAIRS + 1);

    logic [CNT_W-1:0] idle_cnt, idle_cnt_nx;
    line_state_e      state_nx;
    logic             jk_pair, idle_pair, frame_pair;

    always_comb begin
        jk_pair    = (dec_hi.cls == CLS_JK) && !dec_hi.k_half &&
                     (dec_lo.cls == CLS_JK) && dec_lo.k_half;
        idle_pair  = (dec_hi.cls == CLS_IDLE) && (dec_lo.cls == CLS_IDLE);
        frame_pair = in_frame(dec_hi.cls) && in_frame(dec_lo.cls);

        if (!idle_pair)
            idle_cnt_nx = '0;
        else if (idle_cnt == CNT_W'(IDLE_PAIRS))
            idle_cnt_nx = idle_cnt;
        else
            idle_cnt_nx = idle_cnt + 1'b1;

        if (jk_pair)
            state_nx = LS_ACTIVE;
        else if (state == LS_ACTIVE && frame_pair)
            state_nx = LS_ACTIVE;
        else if (idle_cnt_nx == CNT_W'(IDLE_PAIRS))
            state_nx = LS_IDLE;
        else
            state_nx = LS_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= LS_NONE;
            idle_cnt <= '0;
        end else if (in_valid) begin
            state    <= state_nx;
            idle_cnt <= idle_cnt_nx;
        end
    end

    // R8
    idle_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        idle_cnt <= CNT_W'(IDLE_PAIRS));

    // R10
    gap_cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(idle_cnt));
endmodule

// File: rtl/fdx_pair_decoder.sv
module fdx_pair_decoder
    import fdx_pkg::*;
#(
    parameter int IDLE_PAIRS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [SYM_W-1:0] sym_hi,
    input  logic [SYM_W-1:0] sym_lo,
    output logic             out_valid,
    output logic [NIB_W-1:0] nib_hi,
    output logic [NIB_W-1:0] nib_lo,
    output logic [CLS_W-1:0] cls_hi,
    output logic [CLS_W-1:0] cls_lo,
    output logic [LS_W-1:0]  line_state
);
    localparam int NSYM = 2;

    logic [SYM_W-1:0] syms [NSYM];
    sym_dec_t         dec  [NSYM];
    sym_dec_t         dec_q[NSYM];
    line_state_e      ls;

    assign syms[0] = sym_hi;
    assign syms[1] = sym_lo;

    for (genvar g = 0; g < NSYM; g++) begin : g_dec
        fdx_sym_decode u_dec (.code(syms[g]), .dec(dec[g]));

        always_ff @(posedge clk) begin
            if (rst)
                dec_q[g] <= '{nib: '0, cls: CLS_DATA, k_half: 1'b0};
            else if (in_valid)
                dec_q[g] <= dec[g];
        end
    end

    fdx_line_tracker #(.IDLE_PAIRS(IDLE_PAIRS)) u_trk (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .dec_hi(dec[0]), .dec_lo(dec[1]), .state(ls)
    );

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
    end

    assign nib_hi     = dec_q[0].nib;
    assign nib_lo     = dec_q[1].nib;
    assign cls_hi     = dec_q[0].cls;
    assign cls_lo     = dec_q[1].cls;
    assign line_state = ls;

    // R4
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R4
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R5
    jk_to_active_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sym_hi == CODE_J && sym_lo == CODE_K) |=> line_state == LS_ACTIVE);
    // R6
    frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && line_state == LS_ACTIVE && in_frame(dec[0].cls) && in_frame(dec[1].cls))
        |=> line_state == LS_ACTIVE);
    // R7
    viol_leaves_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (dec[0].cls == CLS_VIOL || dec[1].cls == CLS_VIOL)) |=> line_state == LS_NONE);
    // R8
    idle_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (line_state == LS_IDLE && $past(line_state) != LS_IDLE)
        |-> $past(in_valid && sym_hi == CODE_IDLE && sym_lo == CODE_IDLE));
    // R10
    gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(line_state));
endmodule

// File: tb/fdx_pair_decoder_bench.sv
module fdx_pair_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [4:0] sym_hi = '0, sym_lo = '0;
    logic       out_valid;
    logic [3:0] nib_hi, nib_lo;
    logic [2:0] cls_hi, cls_lo;
    logic [1:0] line_state;

    fdx_pair_decoder u_fdx_pair_decoder (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [3:0] nh, nl;
        logic [2:0] ch, cl;
        logic [1:0] ls;
    } exp_t;

    exp_t  exp_q[$];
    string dtag_q[$];
    string ltag_q[$];

    int n_cmp = 0, n_bad = 0;
    logic [1:0] last_ls = 2'd0;
    logic [1:0] m_ls = 2'd0;
    int         m_cnt = 0;
    bit         done = 0;

    localparam logic [4:0] DATA_TBL [16] = '{
        5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011, 5'b01110, 5'b01111,
        5'b10010, 5'b10011, 5'b10110, 5'b10111, 5'b11010, 5'b11011, 5'b11100, 5'b11101};

    // Reference decode built from R1..R3
    function automatic void ref_dec(input logic [4:0] c, output logic [3:0] n, output logic [2:0] k);
        n = 4'h2; k = 3'd7;
        for (int i = 0; i < 16; i++) if (DATA_TBL[i] == c) begin n = 4'(i); k = 3'd0; end
        case (c)
            5'b11111: begin n = 4'hA; k = 3'd1; end
            5'b00100: begin n = 4'h1; k = 3'd2; end
            5'b11000, 5'b10001: begin n = 4'hD; k = 3'd3; end
            5'b01101: begin n = 4'h5; k = 3'd4; end
            5'b00111: begin n = 4'h6; k = 3'd5; end
            5'b11001: begin n = 4'h7; k = 3'd5; end
            5'b00000: begin n = 4'h2; k = 3'd6; end
            default: ;
        endcase
    endfunction

    function automatic bit framey(logic [2:0] k);
        return k == 3'd0 || k == 3'd4 || k == 3'd5;
    endfunction

    function automatic string ctag(logic [2:0] k);
        return (k == 3'd0) ? "R1" : (k == 3'd7) ? "R3" : "R2";
    endfunction

    task automatic send(input logic [4:0] h, input logic [4:0] l, input string ltag);
        exp_t e;
        bit jk, idl;
        @(negedge clk);
        in_valid = 1'b1; sym_hi = h; sym_lo = l;
        ref_dec(h, e.nh, e.ch);
        ref_dec(l, e.nl, e.cl);
        jk  = (h == 5'b11000) && (l == 5'b10001);
        idl = (h == 5'b11111) && (l == 5'b11111);
        if (jk) begin m_cnt = 0; m_ls = 2'd1; end
        else begin
            m_cnt = idl ? ((m_cnt < 2) ? m_cnt + 1 : 2) : 0;
            if (m_ls == 2'd1 && framey(e.ch) && framey(e.cl)) m_ls = 2'd1;
            else m_ls = (m_cnt == 2) ? 2'd2 : 2'd0;
        end
        e.ls = m_ls;
        exp_q.push_back(e);
        dtag_q.push_back((e.ch != 3'd0) ? ctag(e.ch) : ctag(e.cl));
        ltag_q.push_back(ltag);
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; sym_hi = 5'b00001; sym_lo = 5'b00000;
        end
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (rst || done) continue;
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R4: out_valid=1 expected 0 (no pair pending)");
                end else begin
                    exp_t e;
                    string dt, lt;
                    e = exp_q.pop_front(); dt = dtag_q.pop_front(); lt = ltag_q.pop_front();
                    n_cmp++;
                    if ({nib_hi, nib_lo, cls_hi, cls_lo} !== {e.nh, e.nl, e.ch, e.cl}) begin
                        n_bad++;
                        $display("FAIL %s: nib/cls actual %h %h %0d %0d expected %h %h %0d %0d",
                                 dt, nib_hi, nib_lo, cls_hi, cls_lo, e.nh, e.nl, e.ch, e.cl);
                    end
                    n_cmp++;
                    if (line_state !== e.ls) begin
                        n_bad++;
                        $display("FAIL %s: line_state actual %0d expected %0d", lt, line_state, e.ls);
                    end
                    last_ls = e.ls;
                end
            end else begin
                n_cmp++;
                if (line_state !== last_ls) begin
                    n_bad++;
                    $display("FAIL R10: line_state in gap actual %0d expected %0d", line_state, last_ls);
                end
            end
        end
    end

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                #(CLK_PERIOD/4);
                n_cmp++;
                if (line_state !== 2'd0 || out_valid !== 1'b0) begin
                    n_bad++;
                    $display("FAIL R9: ls=%0d ov=%0d expected 0 0", line_state, out_valid);
                end
                @(negedge clk); rst = 1'b0;

                // R1 R2 R3: every code in both positions
                for (int i = 0; i < 32; i++) send(5'(i), 5'(31 - i), "R7");
                for (int i = 0; i < 32; i++) send(5'(i), 5'(i), "R7");

                // R8: idle run
                send(5'b11111, 5'b11111, "R8");
                send(5'b11111, 5'b11111, "R8");
                send(5'b11111, 5'b11111, "R8");
                send(5'b11110, 5'b01001, "R8");
                // R5, R6: frame
                send(5'b11000, 5'b10001, "R5");
                for (int i = 0; i < 8; i++) send(DATA_TBL[i], DATA_TBL[15 - i], "R6");
                send(5'b01101, 5'b00111, "R6");
                send(5'b11001, 5'b01101, "R6");
                send(5'b11000, 5'b10001, "R5");
                gap(3);
                send(5'b10100, 5'b01101, "R10");
                // R7 exits
                send(5'b10100, 5'b00001, "R7");
                send(5'b11000, 5'b10001, "R5");
                send(5'b00100, 5'b00100, "R7");
                send(5'b11000, 5'b10001, "R5");
                send(5'b00000, 5'b11110, "R7");
                send(5'b11000, 5'b10001, "R5");
                send(5'b10001, 5'b11000, "R7");
                send(5'b11000, 5'b10001, "R5");
                send(5'b11111, 5'b11111, "R7");
                send(5'b11111, 5'b11111, "R8");
                // R5 from Idle
                send(5'b11000, 5'b10001, "R5");
                // R10: idle run split by gaps
                send(5'b11111, 5'b11111, "R10");
                gap(4);
                send(5'b11111, 5'b11111, "R10");
                gap(2);
                send(5'b11111, 5'b00100, "R8");
                send(5'b11111, 5'b11111, "R8");
                gap(4);
                done = 1;
                n_cmp++;
                if (exp_q.size() != 0) begin
                    n_bad++;
                    $display("FAIL R4: pending pairs actual %0d expected 0", exp_q.size());
                end
            end
            begin
                repeat (WATCHDOG) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL R4: watchdog expired actual running expected done");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule